// File: doc/BRIEF.md
# Fractional Feedback Divider Margining Controller

This block produces the feedback divider word of a fractional PLL as two fields: a 7-bit integer part and a 9-bit fraction. In normal operation it holds the divider at its nominal setting, which is 100 with a fraction of zero. A margining test can then pull every output clock of the PLL slightly off frequency while the reference input stays put. When the test enable is high, a signed step count moves the divider by whole fraction LSBs. Each step is worth 19.53125 ppm of output frequency, and the usable range is 26 steps on either side of nominal, or ±507.8125 ppm.

A negative offset takes one from the integer part and wraps the fraction downward, so that the two fields together always form one continuous fixed-point number. Step requests beyond the usable range are limited to the nearest end of the range. The step request is assumed to sit already in a control register, and both outputs are registered.

Top module: `margin_div_ctrl`

## Requirements
- R1: While reset is high, the outputs settle to the nominal word: integer 100 (7'b1100100) and fraction 0 on the clock edge that samples reset.
- R2: When the test enable is low, the outputs show the nominal word whatever the step request holds.
- R3: When the test enable is high and the step request is 0, the outputs show the nominal word.
- R4: When the test enable is high and the step request is +k for k from 1 to 26, the integer is 100 and the fraction is k. For example, +26 gives 7'b1100100 with 9'b000011010.
- R5: When the test enable is high and the step request is -k for k from 1 to 26, the integer is 99 and the fraction is 512-k. For example, -1 gives 7'b1100011 with 9'b111111111, and -26 gives 7'b1100011 with 9'b111100110.
- R6: A step request from +27 to +31 produces the same output as +26.
- R7: A step request from -27 to -32 produces the same output as -26.
- R8: The outputs follow the test enable and the step request one clock edge after these inputs change, and they hold steady while the inputs hold.
- R9: The step request is a 6-bit two's complement number. For example, 6'b111111 is -1 and 6'b100000 is -32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| margin_en | input | 1 | Test enable for frequency margining |
| step_req | input | 6 | Signed step request, two's complement |
| fb_int | output | 7 | Integer part of the feedback divider |
| fb_frac | output | 9 | Fractional part of the feedback divider |

## Verification
Two functions can act in the same clock edge: the enable gating and the range clamp. This happens when the test enable switches in the very cycle the step request jumps to an out-of-range value. The bench drives both inputs together on one falling edge. It expects the old word just before the next rising edge and, right after that edge, either the nominal word or the clamped limit, depending on the new enable level. A second collision comes from the borrow at the field boundary when the request crosses from +1 to -1. That single input change must move both fields in one edge, and any stale integer field is treated as a failure.

// File: rtl/margin_div_pkg.sv
package margin_div_pkg;

   typedef enum logic [0:0] {
      ADD_WIDE  = 1'b0,
      ADD_SPLIT = 1'b1
   } add_arch_e;

endpackage

// File: rtl/margin_step_clamp.sv
module margin_step_clamp #(
   parameter int STEP_W   = 6,
   parameter int MAX_STEP = 26
) (
   input  logic [STEP_W-1:0] step_in,
   input  logic              enable,
   output logic [STEP_W-1:0] step_out
);
   localparam logic signed [STEP_W-1:0] HI = STEP_W'(MAX_STEP);
   localparam logic signed [STEP_W-1:0] LO = -HI;

   logic signed [STEP_W-1:0] s_in;
   assign s_in = $signed(step_in);

   always_comb begin
      if (!enable)
         step_out = '0;
      else if (s_in > HI)
         step_out = HI;
      else if (s_in < LO)
         step_out = LO;
      else
         step_out = step_in;
   end
endmodule

// File: rtl/margin_div_offset.sv
module margin_div_offset
   import margin_div_pkg::*;
#(
   parameter int        INT_W    = 7,
   parameter int        FRAC_W   = 9,
   parameter int        STEP_W   = 6,
   parameter int        NOM_INT  = 100,
   parameter int        NOM_FRAC = 0,
   parameter add_arch_e ARCH     = ADD_SPLIT
) (
   input  logic [STEP_W-1:0] step,
   output logic [INT_W-1:0]  int_o,
   output logic [FRAC_W-1:0] frac_o
);
   localparam int WORD_W = INT_W + FRAC_W;
   localparam logic [INT_W-1:0]  NOM_I = INT_W'(NOM_INT);
   localparam logic [FRAC_W-1:0] NOM_F = FRAC_W'(NOM_FRAC);

   generate
      if (ARCH == ADD_WIDE) begin : g_wide
         logic [WORD_W-1:0] word;
         assign word   = {NOM_I, NOM_F} + {{(WORD_W-STEP_W){step[STEP_W-1]}}, step};
         assign int_o  = word[WORD_W-1:FRAC_W];
         assign frac_o = word[FRAC_W-1:0];
      end else begin : g_split
         localparam int SW = FRAC_W + 2;
         logic signed [SW-1:0] fsum;
         assign fsum = $signed({2'b00, NOM_F}) +
                       $signed({{(SW-STEP_W){step[STEP_W-1]}}, step});
         always_comb begin
            if (fsum < 0) begin
               int_o  = NOM_I - INT_W'(1);
               frac_o = fsum[FRAC_W-1:0];
            end else if (fsum[FRAC_W]) begin
               int_o  = NOM_I + INT_W'(1);
               frac_o = fsum[FRAC_W-1:0];
            end else begin
               int_o  = NOM_I;
               frac_o = fsum[FRAC_W-1:0];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/margin_div_ctrl.sv
module margin_div_ctrl
   import margin_div_pkg::*;
#(
   parameter int        INT_W    = 7,
   parameter int        FRAC_W   = 9,
   parameter int        STEP_W   = 6,
   parameter int        MAX_STEP = 26,
   parameter int        NOM_INT  = 100,
   parameter int        NOM_FRAC = 0,
   parameter add_arch_e ARCH     = ADD_SPLIT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              margin_en,
   input  logic [STEP_W-1:0] step_req,
   output logic [INT_W-1:0]  fb_int,
   output logic [FRAC_W-1:0] fb_frac
);
   generate
      if (MAX_STEP > (2 ** (STEP_W - 1)) - 1) begin : g_bad_step
         $error("MAX_STEP does not fit the signed step width");
      end
      if (MAX_STEP >= (2 ** FRAC_W)) begin : g_bad_frac
         $error("MAX_STEP exceeds one integer unit of the fraction");
      end
      if (NOM_INT < 1 || NOM_INT >= (2 ** INT_W) - 1) begin : g_bad_int
         $error("NOM_INT leaves no headroom for borrow or carry");
      end
   endgenerate

   logic [STEP_W-1:0] step_eff;
   logic [INT_W-1:0]  nxt_int;
   logic [FRAC_W-1:0] nxt_frac;

   margin_step_clamp #(.STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_clamp (
      .step_in (step_req),
      .enable  (margin_en),
      .step_out(step_eff)
   );

   margin_div_offset #(
      .INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W),
      .NOM_INT(NOM_INT), .NOM_FRAC(NOM_FRAC), .ARCH(ARCH)
   ) u_offset (
      .step  (step_eff),
      .int_o (nxt_int),
      .frac_o(nxt_frac)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         fb_int  <= INT_W'(NOM_INT);
         fb_frac <= FRAC_W'(NOM_FRAC);
      end else begin
         fb_int  <= nxt_int;
         fb_frac <= nxt_frac;
      end
   end
endmodule

// File: rtl/margin_div_chk.sv
module margin_div_chk #(
   parameter int INT_W    = 7,
   parameter int FRAC_W   = 9,
   parameter int STEP_W   = 6,
   parameter int MAX_STEP = 26,
   parameter int NOM_INT  = 100,
   parameter int NOM_FRAC = 0
) (
   input logic              clk,
   input logic              rst,
   input logic              margin_en,
   input logic [STEP_W-1:0] step_req,
   input logic [INT_W-1:0]  fb_int,
   input logic [FRAC_W-1:0] fb_frac
);
   localparam logic [INT_W-1:0]  NI = INT_W'(NOM_INT);
   localparam logic [FRAC_W-1:0] NF = FRAC_W'(NOM_FRAC);

   logic [1:0] age;
   logic       rst_q;
   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   logic ok1, ok2, is_nom;
   assign ok1    = (age >= 2'd1);
   assign ok2    = (age >= 2'd2);
   assign is_nom = (fb_int == NI) && (fb_frac == NF);

   always @(posedge clk) begin
      if (rst_q == 1'b1)
         assert_reset_nominal_R1: assert (is_nom);
   end

   assert_off_nominal_R2: assert property (@(posedge clk) disable iff (rst)
      (ok1 && !$past(margin_en)) |-> is_nom);

   assert_zero_nominal_R3: assert property (@(posedge clk) disable iff (rst)
      (ok1 && $past(margin_en) && $past(step_req) == '0) |-> is_nom);

   assert_pos_step_R4: assert property (@(posedge clk) disable iff (rst)
      (ok1 && $past(margin_en) && $signed($past(step_req)) > 0 &&
       $signed($past(step_req)) <= MAX_STEP)
      |-> (fb_int == NI && fb_frac == FRAC_W'($past(step_req))));

   assert_neg_borrow_R5: assert property (@(posedge clk) disable iff (rst)
      (ok1 && $past(margin_en) && $signed($past(step_req)) < 0 &&
       $signed($past(step_req)) >= -MAX_STEP)
      |-> (fb_int == NI - INT_W'(1)));

   assert_clamp_hi_R6: assert property (@(posedge clk) disable iff (rst)
      (ok1 && $past(margin_en) && $signed($past(step_req)) > MAX_STEP)
      |-> (fb_int == NI && fb_frac == FRAC_W'(MAX_STEP)));

   assert_clamp_lo_R7: assert property (@(posedge clk) disable iff (rst)
      (ok1 && $past(margin_en) && $signed($past(step_req)) < -MAX_STEP)
      |-> (fb_int == NI - INT_W'(1) && fb_frac == FRAC_W'(-MAX_STEP)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (ok2 && $past(margin_en) == $past(margin_en, 2) &&
       $past(step_req) == $past(step_req, 2))
      |-> ($stable(fb_int) && $stable(fb_frac)));
endmodule

bind margin_div_ctrl margin_div_chk #(
   .INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W),
   .MAX_STEP(MAX_STEP), .NOM_INT(NOM_INT), .NOM_FRAC(NOM_FRAC)
) u_chk (
   .clk(clk), .rst(rst), .margin_en(margin_en), .step_req(step_req),
   .fb_int(fb_int), .fb_frac(fb_frac)
);

// File: tb/tb_margin_div_ctrl.sv
module tb_margin_div_ctrl;
   logic       clk = 1'b0;
   logic       rst;
   logic       margin_en;
   logic [5:0] step_req;
   logic [6:0] fb_int;
   logic [8:0] fb_frac;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   margin_div_ctrl dut (
      .clk(clk), .rst(rst), .margin_en(margin_en), .step_req(step_req),
      .fb_int(fb_int), .fb_frac(fb_frac)
   );

   function automatic void model(input bit en, input int s,
                                 output int ei, output int ef);
      int c;
      c = s;
      if (c > 26) c = 26;
      if (c < -26) c = -26;
      if (!en || c == 0) begin ei = 100; ef = 0; end
      else if (c > 0) begin ei = 100; ef = c; end
      else begin ei = 99; ef = 512 + c; end
   endfunction

   task automatic check(input string req, input int ei, input int ef);
      checks++;
      if (fb_int !== 7'(ei) || fb_frac !== 9'(ef)) begin
         errors++;
         $display("FAIL %s: got int=%0d frac=%0d expected int=%0d frac=%0d",
                  req, fb_int, fb_frac, ei, ef);
      end
   endtask

   task automatic apply(input bit en, input int s);
      margin_en = en;
      step_req  = 6'(s);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic apply_check(input string req, input bit en, input int s);
      int ei, ef;
      apply(en, s);
      model(en, s, ei, ef);
      check(req, ei, ef);
   endtask

   task automatic t_reset();
      rst = 1'b1; margin_en = 1'b1; step_req = 6'd20;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 reset", 100, 0);
      rst = 1'b0;
   endtask

   task automatic t_disabled();
      apply_check("R2 off step 10", 1'b0, 10);
      apply_check("R2 off step -32", 1'b0, -32);
      apply_check("R2 off step 31", 1'b0, 31);
   endtask

   task automatic t_zero();
      apply_check("R3 zero step", 1'b1, 0);
   endtask

   task automatic t_positive();
      for (int k = 1; k <= 26; k++) apply_check("R4 positive", 1'b1, k);
   endtask

   task automatic t_negative();
      for (int k = 1; k <= 26; k++) apply_check("R5 negative", 1'b1, -k);
   endtask

   task automatic t_clamp();
      for (int k = 27; k <= 31; k++) apply_check("R6 clamp high", 1'b1, k);
      for (int k = 27; k <= 32; k++) apply_check("R7 clamp low", 1'b1, -k);
   endtask

   task automatic t_encoding();
      margin_en = 1'b1; step_req = 6'b111111;
      @(posedge clk); @(negedge clk);
      check("R9 6'b111111 is -1", 99, 511);
      step_req = 6'b100000;
      @(posedge clk); @(negedge clk);
      check("R9 6'b100000 is -32", 99, 486);
      step_req = 6'b011010;
      @(posedge clk); @(negedge clk);
      check("R9 6'b011010 is +26", 100, 26);
   endtask

   task automatic t_latency();
      apply(1'b1, 1);
      check("R8 settle +1", 100, 1);
      step_req = 6'(-1);
      #1 check("R8 old value before edge", 100, 1);
      @(posedge clk); @(negedge clk);
      check("R8 borrow after edge", 99, 511);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 hold", 99, 511);
   endtask

   task automatic t_collide();
      apply(1'b0, 0);
      margin_en = 1'b1; step_req = 6'd30;
      #1 check("R8 collide before edge", 100, 0);
      @(posedge clk); @(negedge clk);
      check("R6 collide enable with clamp", 100, 26);
      margin_en = 1'b0; step_req = 6'(-30);
      @(posedge clk); @(negedge clk);
      check("R2 collide disable with clamp", 100, 0);
      margin_en = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R7 re-enable clamp low", 99, 486);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_disabled();
      t_zero();
      t_positive();
      t_negative();
      t_clamp();
      t_encoding();
      t_latency();
      t_collide();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule